// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides whether an incoming Ethernet frame is kept. It looks at the 48-bit destination address and compares it against a table of sixteen exact-match addresses. All sixteen comparisons run at the same time. The table is loaded from a setup frame that arrives as a byte stream on its own port. In that stream each address sits in a 12-byte slot, and only six of the slot bytes carry address data. A new table takes effect only once the whole setup frame has arrived and its length is exactly right.

Four mode inputs change the decision: promiscuous, receive-all, pass-all-multicast and inverse matching. The decision follows a fixed priority:

1. The length check.
2. Broadcast.
3. Bypass (promiscuous or receive-all).
4. Multicast.
5. The table match, which inverse mode may invert.

The decision is a one-cycle valid pulse. It comes with an accept bit and two status bits. One status bit says the frame was kept only because filtering was bypassed. The other says it was kept as a multicast frame. The receive path that surrounds the block uses these bits to drop the frame or tag it.

Top module: `dst_addr_filter`

## Requirements
- R1: The table changes only after a setup frame of exactly 192 bytes, whose final byte is marked with `setup_last`. A setup frame of 191, 193 or any other length leaves all sixteen entries as they were.
- R2: Entry n (n = 0..15) takes its destination bytes 0..5, in that order, from setup-frame offsets 12n, 12n+1, 12n+4, 12n+5, 12n+8 and 12n+9. Destination byte 0 is the first byte received on `rx_byte` and is held in bits [7:0] of the address.
- R3: A destination of all ones (FF:FF:FF:FF:FF:FF) is accepted with both status flags low, whatever the four mode inputs are, including inverse mode.
- R4: When `mode_promisc` or `mode_rx_all` is high and the destination is not broadcast, the frame is accepted with `flag_bypass` high and `flag_mcast` low. This holds even if pass-all-multicast is also set.
- R5: When neither bypass mode is set, `mode_all_mcast` is high and bit 0 of destination byte 0 is 1, the frame is accepted with `flag_mcast` high. An even first byte does not take this path.
- R6: In every other case, `accept` equals the OR of the sixteen exact matches, XORed with `mode_inverse`. Both flags are low.
- R7: A frame whose `frm_len` (sampled with the `rx_sof` byte) is below 14 or above 2048 is rejected with both flags low. This check takes priority over broadcast.
- R8: `dec_valid` is high for exactly the one cycle after the clock edge that samples the sixth destination byte. `accept` and the flags hold their value until the next decision.
- R9: Bytes of a setup frame that is still arriving do not affect decisions. Frames decided in the middle of a load use the previous table, even for entries whose slots have already streamed in.
- R10: After reset, `dec_valid`, `accept` and both flags are 0, and every table entry is 00:00:00:00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | A setup-frame byte is present |
| setup_byte | input | 8 | Setup-frame byte |
| setup_last | input | 1 | Marks the final byte of the setup frame |
| rx_valid | input | 1 | A received-frame byte is present |
| rx_sof | input | 1 | Marks destination byte 0 of a frame |
| rx_byte | input | 8 | Received-frame byte |
| frm_len | input | 16 | Total frame length in bytes, valid with `rx_sof` |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_all_mcast | input | 1 | Pass-all-multicast mode |
| mode_inverse | input | 1 | Inverts the table match result |
| dec_valid | output | 1 | Decision pulse |
| accept | output | 1 | Frame is kept |
| flag_bypass | output | 1 | Kept only because filtering was bypassed |
| flag_mcast | output | 1 | Kept as multicast |

## Verification
The bench loads a table and then sweeps every entry, broadcast, and an even and an odd miss address through all sixteen mode combinations.

- A wrong priority order, or a missing inverse XOR, would give the wrong accept bit or flag on part of that sweep.
- Setup frames one byte short and one byte long must leave the old entries working and the new ones rejected. A loader that commits on any `setup_last` would fail this.
- A setup frame is interrupted after half its bytes. Before it completes, the new entry 0 must still be rejected; a loader that writes the live table directly would accept it early.
- The length edges 13, 14, 2048 and 2049 are sent with a broadcast destination, which catches an off-by-one or a broadcast that overrides the length check.
- A check on the exact pulse cycle catches a decision that arrives one cycle early or late.

// File: rtl/af_pkg.sv
// Package: shared constants and the address type for the receive filter.
// Assumes bytes are 8 bits wide and destination byte 0 is the first byte received.
package af_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int SLOT_BYTES = 12;
    typedef logic [ADDR_BYTES-1:0][7:0] mac_t;
endpackage

// File: rtl/af_setup_loader.sv
// Module: af_setup_loader
// Gathers the address bytes of a setup frame into a staging table.
// Raises a one-cycle commit pulse when the frame ends at exactly
// NUM_ENTRIES*12 bytes. Assumes setup_last marks the final byte.
module af_setup_loader
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     setup_valid,
    input  logic [7:0]               setup_byte,
    input  logic                     setup_last,
    output mac_t [NUM_ENTRIES-1:0]   staged_tbl,
    output logic                     load_commit
);
    localparam int TOTAL  = NUM_ENTRIES * SLOT_BYTES;
    localparam int CNT_W  = $clog2(TOTAL + 1);
    localparam int SLOT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [CNT_W-1:0]  byte_cnt;
    logic [SLOT_W-1:0] slot_idx;
    logic [3:0]        off_idx;
    logic              in_range;
    logic [2:0]        byte_sel;

    assign in_range = (byte_cnt < CNT_W'(TOTAL));
    // Only slot offsets 0,1,4,5,8,9 carry address bytes (bit 1 of the offset is clear).
    assign byte_sel = {off_idx[3:2], off_idx[0]};

    // Purpose: track byte position within the setup frame and detect the exact length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt    <= '0;
            slot_idx    <= '0;
            off_idx     <= '0;
            load_commit <= 1'b0;
        end else begin
            load_commit <= 1'b0;
            if (setup_valid) begin
                if (setup_last) begin
                    load_commit <= (byte_cnt == CNT_W'(TOTAL - 1));
                    byte_cnt    <= '0;
                    slot_idx    <= '0;
                    off_idx     <= '0;
                end else if (in_range) begin
                    byte_cnt <= byte_cnt + 1'b1;
                    if (off_idx == 4'(SLOT_BYTES - 1)) begin
                        off_idx  <= '0;
                        slot_idx <= slot_idx + 1'b1;
                    end else begin
                        off_idx <= off_idx + 1'b1;
                    end
                end
            end
        end
    end

    // Purpose: write the address-carrying bytes into the staging table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_tbl <= '0;
        end else if (setup_valid && in_range && !off_idx[1]) begin
            staged_tbl[slot_idx][byte_sel] <= setup_byte;
        end
    end
endmodule

// File: rtl/af_match_array.sv
// Module: af_match_array
// Holds the live address table and compares one destination against every
// entry in parallel. Assumes load_commit only pulses after a complete setup frame.
module af_match_array
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_commit,
    input  mac_t [NUM_ENTRIES-1:0]   staged_tbl,
    input  mac_t                     dest,
    output mac_t [NUM_ENTRIES-1:0]   live_tbl,
    output logic                     hit
);
    logic [NUM_ENTRIES-1:0] hit_vec;

    // Purpose: copy the staged table into the live table when a load completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_tbl <= '0;
        end else if (load_commit) begin
            live_tbl <= staged_tbl;
        end
    end

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_cmp
        assign hit_vec[n] = (live_tbl[n] == dest);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/af_dest_capture.sv
// Module: af_dest_capture
// Collects destination bytes 0..4 and presents the full address while the
// sixth byte is on the input. Judges the frame length when rx_sof arrives.
// Assumes rx_sof marks destination byte 0 and that bytes come in order.
module af_dest_capture
    import af_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_byte,
    input  logic [LEN_W-1:0] frm_len,
    output mac_t             dest,
    output logic             dest_done,
    output logic             len_ok
);
    localparam logic [2:0] IDLE_IDX = 3'(ADDR_BYTES);

    mac_t       hold;
    logic [2:0] idx;

    // Purpose: store the leading destination bytes and the length verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            idx    <= IDLE_IDX;
            len_ok <= 1'b0;
        end else if (rx_valid) begin
            if (rx_sof) begin
                hold[0] <= rx_byte;
                idx     <= 3'd1;
                len_ok  <= (frm_len >= LEN_W'(MIN_LEN)) && (frm_len <= LEN_W'(MAX_LEN));
            end else if (idx < IDLE_IDX) begin
                hold[idx] <= rx_byte;
                idx       <= idx + 3'd1;
            end
        end
    end

    // Purpose: form the complete address with the last byte taken from the input.
    always_comb begin
        dest                 = hold;
        dest[ADDR_BYTES-1]   = rx_byte;
    end

    assign dest_done = rx_valid && !rx_sof && (idx == 3'(ADDR_BYTES - 1));
endmodule

// File: rtl/dst_addr_filter.sv
// Module: dst_addr_filter (top)
// Destination-address receive filter: a staged exact-match table, parallel
// compare, and a registered decision with priority length > broadcast >
// bypass > multicast > match/inverse. Assumes the mode inputs are steady
// around the sixth destination byte.
module dst_addr_filter
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int LEN_W       = 16,
    parameter int MIN_LEN     = 14,
    parameter int MAX_LEN     = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [7:0]       setup_byte,
    input  logic             setup_last,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic [7:0]       rx_byte,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             mode_promisc,
    input  logic             mode_rx_all,
    input  logic             mode_all_mcast,
    input  logic             mode_inverse,
    output logic             dec_valid,
    output logic             accept,
    output logic             flag_bypass,
    output logic             flag_mcast
);
    mac_t [NUM_ENTRIES-1:0] staged_tbl;
    mac_t [NUM_ENTRIES-1:0] live_tbl;
    logic                   load_commit;
    mac_t                   dest;
    logic                   dest_done;
    logic                   len_ok;
    logic                   hit;
    logic                   nxt_acc, nxt_byp, nxt_mc;

    af_setup_loader #(.NUM_ENTRIES(NUM_ENTRIES)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .setup_valid (setup_valid),
        .setup_byte  (setup_byte),
        .setup_last  (setup_last),
        .staged_tbl  (staged_tbl),
        .load_commit (load_commit)
    );

    af_match_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_commit (load_commit),
        .staged_tbl  (staged_tbl),
        .dest        (dest),
        .live_tbl    (live_tbl),
        .hit         (hit)
    );

    af_dest_capture #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_byte   (rx_byte),
        .frm_len   (frm_len),
        .dest      (dest),
        .dest_done (dest_done),
        .len_ok    (len_ok)
    );

    // Purpose: apply the fixed decision priority to the current destination.
    always_comb begin
        nxt_acc = 1'b0;
        nxt_byp = 1'b0;
        nxt_mc  = 1'b0;
        if (!len_ok) begin
            nxt_acc = 1'b0;
        end else if (&dest) begin
            nxt_acc = 1'b1;
        end else if (mode_promisc || mode_rx_all) begin
            nxt_acc = 1'b1;
            nxt_byp = 1'b1;
        end else if (mode_all_mcast && dest[0][0]) begin
            nxt_acc = 1'b1;
            nxt_mc  = 1'b1;
        end else begin
            nxt_acc = hit ^ mode_inverse;
        end
    end

    // Purpose: register the decision pulse and hold the result until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            accept      <= 1'b0;
            flag_bypass <= 1'b0;
            flag_mcast  <= 1'b0;
        end else begin
            dec_valid <= dest_done;
            if (dest_done) begin
                accept      <= nxt_acc;
                flag_bypass <= nxt_byp;
                flag_mcast  <= nxt_mc;
            end
        end
    end
endmodule

// File: rtl/af_filter_checker.sv
// Module: af_filter_checker
// Temporal checks on the filter's decision outputs and on the live table.
// Attached to every dst_addr_filter instance by the bind below.
module af_filter_checker
    import af_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_valid,
    input logic                   mode_promisc,
    input logic                   mode_rx_all,
    input logic                   mode_all_mcast,
    input logic                   dec_valid,
    input logic                   accept,
    input logic                   flag_bypass,
    input logic                   flag_mcast,
    input logic                   load_commit,
    input mac_t [NUM_ENTRIES-1:0] live_tbl
);
    // R4/R5: the two status flags never appear together.
    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(flag_bypass && flag_mcast));

    // R5: a raised flag always comes with acceptance.
    p_flag_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (flag_bypass || flag_mcast)) |-> accept);

    // R4: the bypass flag requires a bypass mode at the deciding edge.
    p_bypass_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && flag_bypass) |-> $past(mode_promisc || mode_rx_all));

    // R5: the multicast flag requires pass-all-multicast at the deciding edge.
    p_mcast_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && flag_mcast) |-> $past(mode_all_mcast));

    // R8: a decision pulse follows a sampled receive byte.
    p_dec_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    // R8: the decision is a single-cycle pulse.
    p_dec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R1/R9: the live table changes only on a completed load.
    p_table_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_tbl) |-> $past(load_commit));
endmodule

bind dst_addr_filter af_filter_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_af_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_valid       (rx_valid),
    .mode_promisc   (mode_promisc),
    .mode_rx_all    (mode_rx_all),
    .mode_all_mcast (mode_all_mcast),
    .dec_valid      (dec_valid),
    .accept         (accept),
    .flag_bypass    (flag_bypass),
    .flag_mcast     (flag_mcast),
    .load_commit    (load_commit),
    .live_tbl       (live_tbl)
);

// File: tb/dst_addr_filter_tb_top.sv
// Bench for dst_addr_filter: keeps its own model table built from the setup
// byte formula and sweeps modes and addresses against it.
module dst_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [7:0]  setup_byte = '0;
    logic        setup_last = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] frm_len = '0;
    logic        mode_promisc = 1'b0;
    logic        mode_rx_all = 1'b0;
    logic        mode_all_mcast = 1'b0;
    logic        mode_inverse = 1'b0;
    logic        dec_valid, accept, flag_bypass, flag_mcast;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [47:0] mt [16];

    always #5 clk = ~clk;

    dst_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_byte(setup_byte), .setup_last(setup_last),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte), .frm_len(frm_len),
        .mode_promisc(mode_promisc), .mode_rx_all(mode_rx_all),
        .mode_all_mcast(mode_all_mcast), .mode_inverse(mode_inverse),
        .dec_valid(dec_valid), .accept(accept),
        .flag_bypass(flag_bypass), .flag_mcast(flag_mcast)
    );

    function automatic logic [7:0] sval(int seed, int off);
        return 8'((off * 13 + seed) & 255);
    endfunction

    // Model load following R2: byte k of entry n from offset 12n + (k/2)*4 + k%2.
    task automatic model_load(int seed);
        for (int n = 0; n < 16; n++)
            for (int k = 0; k < 6; k++)
                mt[n][8*k +: 8] = sval(seed, 12*n + (k/2)*4 + (k%2));
    endtask

    function automatic logic [2:0] model_dec(logic [47:0] d, int len);
        logic h;
        if (len < 14 || len > 2048) return 3'b000;
        if (d == '1) return 3'b100;
        if (mode_promisc || mode_rx_all) return 3'b110;
        if (mode_all_mcast && d[0]) return 3'b101;
        h = 1'b0;
        for (int n = 0; n < 16; n++) if (mt[n] == d) h = 1'b1;
        return {h ^ mode_inverse, 2'b00};
    endfunction

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {valid,accept,bypass,mcast} got %b expected %b", tag, got, exp);
        end
    endtask

    // Send setup bytes at offsets [first..last_off]; mark the final one when mark_last.
    task automatic send_setup(int seed, int first, int last_off, bit mark_last);
        for (int o = first; o <= last_off; o++) begin
            @(negedge clk);
            setup_valid = 1'b1;
            setup_byte  = sval(seed, o);
            setup_last  = mark_last && (o == last_off);
        end
        @(negedge clk);
        setup_valid = 1'b0;
        setup_last  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Send six destination bytes, then check the decision one edge after the sixth.
    task automatic send_frame(string tag, logic [47:0] d, int len);
        logic [2:0] e;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (k == 0);
            rx_byte  = d[8*k +: 8];
            frm_len  = 16'(len);
        end
        e = model_dec(d, len);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        chk(tag, {dec_valid, accept, flag_bypass, flag_mcast}, {1'b1, e});
    endtask

    function automatic string pick_tag(logic [47:0] d);
        if (d == '1) return "R3";
        if (mode_promisc || mode_rx_all) return "R4";
        if (mode_all_mcast && d[0]) return "R5";
        return "R6";
    endfunction

    task automatic set_modes(int m);
        mode_promisc   = m[0];
        mode_rx_all    = m[1];
        mode_all_mcast = m[2];
        mode_inverse   = m[3];
    endtask

    initial begin
        logic [47:0] a;
        logic [47:0] wrong;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", {dec_valid, accept, flag_bypass, flag_mcast}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {dec_valid, accept, flag_bypass, flag_mcast}, 4'b0000);
        for (int n = 0; n < 16; n++) mt[n] = '0;
        send_frame("R10", 48'h0, 64);

        // R1/R2: full load, then every entry and a contiguous-offset misread.
        send_setup(3, 0, 191, 1'b1);
        model_load(3);
        for (int n = 0; n < 16; n++) send_frame("R2", mt[n], 64);
        for (int k = 0; k < 6; k++) wrong[8*k +: 8] = sval(3, 12*5 + k);
        send_frame("R2", wrong, 64);
        send_frame("R1", 48'h0, 64);

        // R6/R5/R4/R3: sweep all mode combinations.
        for (int m = 0; m < 16; m++) begin
            set_modes(m);
            for (int n = 0; n < 16; n++) send_frame(pick_tag(mt[n]), mt[n], 100);
            a = 48'h6655_4433_2200; send_frame(pick_tag(a), a, 100);
            a = 48'h6655_4433_2201; send_frame(pick_tag(a), a, 100);
            a = '1;                 send_frame(pick_tag(a), a, 100);
        end
        set_modes(0);

        // R7: length limits, with broadcast and with a table hit.
        send_frame("R7", '1, 13);
        send_frame("R7", '1, 14);
        send_frame("R7", '1, 2048);
        send_frame("R7", '1, 2049);
        send_frame("R7", mt[4], 13);
        set_modes(1);
        send_frame("R7", 48'h1, 2049);
        set_modes(0);

        // R1: short and long setup frames leave the table alone.
        send_setup(77, 0, 190, 1'b1);
        send_frame("R1", mt[0], 64);
        a = {sval(77,9), sval(77,8), sval(77,5), sval(77,4), sval(77,1), sval(77,0)};
        send_frame("R1", a, 64);
        send_setup(77, 0, 192, 1'b1);
        send_frame("R1", mt[15], 64);
        send_frame("R1", a, 64);

        // R9: half-loaded table is not visible.
        send_setup(77, 0, 99, 1'b0);
        send_frame("R9", mt[0], 64);
        send_frame("R9", a, 64);
        send_setup(77, 100, 191, 1'b1);
        model_load(77);
        send_frame("R9", a, 64);
        send_frame("R9", mt[15], 64);

        // R8: exact pulse timing and hold.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = mt[2][8*k +: 8]; frm_len = 16'd64;
        end
        chk("R8", {dec_valid, 3'b000}, 4'b0000);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk("R8", {dec_valid, accept, flag_bypass, flag_mcast}, 4'b1100);
        repeat (3) @(negedge clk);
        chk("R8", {dec_valid, accept, flag_bypass, flag_mcast}, 4'b0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule